// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

This block gathers up to 31 external interrupt lines and presents them to two processor contexts. Software sets a 3-bit priority per source, a per-context enable mask, and a per-context threshold. It does all of this through a plain 32-bit register bus. Each context gets one registered interrupt line. The line is high whenever some pending source that the context has enabled carries a priority above that context's threshold.

A handler reads its context's claim register. The read returns the best waiting source and clears that source's pending bit. While the source is being serviced, its gateway takes no new requests from it. The handler then writes the same ID back to the same register to finish. A source that is still held high (level mode) is then seen again. A source in edge mode waits for a fresh rising edge. A parameter picks level or rising-edge capture for each source.

Top module: `plic_top`

## Requirements
- R1: After reset every interrupt output is low, every priority, enable and threshold register reads 0, and a claim read returns 0.
- R2: The priority of source id (1..31) is at byte offset 4*id. Only bits [2:0] are stored and the upper bits read 0. Offset 0 (source 0) reads 0 and ignores writes.
- R3: The enable word of context c is at 0x2000 + c*0x80. Bit id enables source id, and bit 0 always reads 0.
- R4: Context c has its threshold at 0x200000 + c*0x1000 (3 bits, upper bits read 0) and its claim/complete register at that base + 4.
- R5: A context's output is asserted only for a source that is pending, enabled for that context, and has a priority strictly above the context's threshold. Priority 0 never interrupts, and threshold 7 blocks everything.
- R6: The interrupt output is registered. It reacts in the cycle after the one in which an enable, priority, threshold or pending bit changes.
- R7: A claim read returns the highest-priority eligible source. On a tie the lowest ID wins. When nothing is eligible the read returns 0.
- R8: A claim clears the source's pending bit. Until its completion, the source cannot become pending again, even while its line stays high.
- R9: Completing a level source whose line is still high makes it pending again.
- R10: An edge source becomes pending only on a rising edge of its line while it is not in flight. Edges that occur while it is claimed are dropped.
- R11: A completion write carrying an ID that is not in flight for that same context has no effect.
- R12: The contexts are independent. Each uses only its own enable mask and threshold, and claims only from that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| irq_src_i | input | 31 | Interrupt lines; bit k is source ID k+1 |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 22 | Byte address; bits [1:0] must be 0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe and held until the next read |
| ctx_irq_o | output | 2 | Registered interrupt request, one per context |

## Verification
Arbitration is tried with three patterns, and each tells a different fault apart. Two equal-priority sources plus a lower one check both the tie rule and the priority order. The same level line is held high across claim and completion, which separates blocking while in flight from re-arming. A rising edge inside the claimed window shows whether edge capture wrongly remembers pulses. Threshold sweeps of 0, equal-to-priority, and 7 expose an off-by-one in the strict comparison. A completion sent from the wrong context, and a cross-context enable pattern, show that ownership and masks are kept per context.

// File: rtl/plic_pkg.sv
package plic_pkg;
  localparam int ADDR_W   = 22;
  localparam int DATA_W   = 32;
  localparam int PRIO_W   = 3;
  localparam int MAX_SRC  = 31;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o
);
  logic pend_q, pend_d, busy_q, busy_d, trig;

  generate
    if (EDGE) begin : g_edge
      logic src_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) src_q <= 1'b0;
        else         src_q <= src_i;
      end
      assign trig = src_i & ~src_q;

      AST_EDGE_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q) |-> ($past(src_i, 1) && !$past(src_i, 2))); // R10
    end else begin : g_level
      assign trig = src_i;
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (claim_i) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else begin
      if (complete_i) busy_d = 1'b0;
      if (!busy_q && trig) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign pend_o = pend_q;

  AST_BUSY_NOT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !pend_q); // R8
  AST_CLAIM_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> (!pend_q && busy_q)); // R8
endmodule

// File: rtl/plic_ctx_arb.sv
module plic_ctx_arb #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NSRC-1:0]              pend_i,
  input  logic [NSRC-1:0]              en_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [ID_W-1:0]              best_id_o,
  output logic                         best_vld_o,
  output logic                         irq_o
);
  logic [PRIO_W-1:0] best_p;
  logic              irq_q;

  always_comb begin
    best_p     = '0;
    best_id_o  = '0;
    best_vld_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i) &&
          (!best_vld_o || (prio_i[i] > best_p))) begin
        best_vld_o = 1'b1;
        best_p     = prio_i[i];
        best_id_o  = ID_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= best_vld_o;
  end

  assign irq_o = irq_q;

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(|(pend_i & en_i))); // R5
endmodule

// File: rtl/plic_top.sv
module plic_top
  import plic_pkg::*;
#(
  parameter int            NSRC     = 31,
  parameter int            NCTX     = 2,
  parameter logic [NSRC-1:0] EDGE_SRC = 31'h7FFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   irq_src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NCTX-1:0]   ctx_irq_o
);
  localparam int ID_W = $clog2(NSRC + 1);

  logic [NSRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NCTX-1:0][NSRC-1:0]   en_q, en_d, infl_q, infl_d;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic [DATA_W-1:0]           rdata_q, rdata_d;
  logic                        rd_en;
  logic [NSRC-1:0]             claim_v, cmpl_v, pend;
  logic [NCTX-1:0][ID_W-1:0]   best_id;
  logic [NCTX-1:0]             best_vld;

  logic hit_prio, hit_en, hit_ctx, claim_reg;
  int   src_id, en_ctx, ctx_sel, wid;

  always_comb begin
    hit_prio  = (bus_addr_i[21:7] == '0) && (bus_addr_i[1:0] == 2'b00);
    src_id    = int'(bus_addr_i[6:2]);
    en_ctx    = int'(bus_addr_i[12:7]);
    hit_en    = (bus_addr_i[21:13] == 9'd1) && (bus_addr_i[6:0] == 7'd0) && (en_ctx < NCTX);
    ctx_sel   = int'(bus_addr_i[20:12]);
    hit_ctx   = bus_addr_i[21] && (bus_addr_i[11:3] == '0) && (bus_addr_i[1:0] == 2'b00) &&
                (ctx_sel < NCTX);
    claim_reg = bus_addr_i[2];
    wid       = int'(bus_wdata_i[ID_W-1:0]);
  end

  always_comb begin
    prio_d  = prio_q;
    en_d    = en_q;
    thr_d   = thr_q;
    infl_d  = infl_q;
    rdata_d = '0;
    rd_en   = bus_req_i && !bus_we_i;
    claim_v = '0;
    cmpl_v  = '0;
    if (bus_req_i && bus_we_i) begin
      if (hit_prio && src_id != 0 && src_id <= NSRC)
        prio_d[src_id-1] = bus_wdata_i[PRIO_W-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (hit_en && en_ctx == c) en_d[c] = bus_wdata_i[NSRC:1];
        if (hit_ctx && ctx_sel == c && !claim_reg) thr_d[c] = bus_wdata_i[PRIO_W-1:0];
        if (hit_ctx && ctx_sel == c && claim_reg && wid != 0 && wid <= NSRC &&
            bus_wdata_i[DATA_W-1:ID_W] == '0 && infl_q[c][wid-1]) begin
          cmpl_v[wid-1]    = 1'b1;
          infl_d[c][wid-1] = 1'b0;
        end
      end
    end else if (rd_en) begin
      if (hit_prio && src_id != 0 && src_id <= NSRC)
        rdata_d = DATA_W'(prio_q[src_id-1]);
      for (int c = 0; c < NCTX; c++) begin
        if (hit_en && en_ctx == c) rdata_d = DATA_W'({en_q[c], 1'b0});
        if (hit_ctx && ctx_sel == c && !claim_reg) rdata_d = DATA_W'(thr_q[c]);
        if (hit_ctx && ctx_sel == c && claim_reg) begin
          rdata_d = DATA_W'(best_id[c]);
          if (best_vld[c]) begin
            claim_v[int'(best_id[c]) - 1]     = 1'b1;
            infl_d[c][int'(best_id[c]) - 1]   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      infl_q  <= '0;
      rdata_q <= '0;
    end else begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
      infl_q <= infl_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [NCTX-1:0] owner;
    for (genvar c = 0; c < NCTX; c++) begin : g_own
      assign owner[c] = infl_q[c][i];
    end
    plic_gateway #(.EDGE(EDGE_SRC[i])) u_gw (
      .clk_i(clk_i), .rst_ni(rst_ni), .src_i(irq_src_i[i]),
      .claim_i(claim_v[i]), .complete_i(cmpl_v[i]), .pend_o(pend[i])
    );
    AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owner)); // R11
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    plic_ctx_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .en_i(en_q[c]),
      .prio_i(prio_q), .thr_i(thr_q[c]), .best_id_o(best_id[c]),
      .best_vld_o(best_vld[c]), .irq_o(ctx_irq_o[c])
    );
  end

  AST_CLAIM_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(claim_v) <= 1); // R7
endmodule

// File: tb/tb_plic_top.sv
module tb_plic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [21:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [21:0] C0_THR = 22'h200000, C0_CLM = 22'h200004;
  localparam logic [21:0] C1_THR = 22'h201000, C1_CLM = 22'h201004;
  localparam logic [21:0] C0_EN  = 22'h002000, C1_EN  = 22'h002080;

  always #4 clk = ~clk;

  plic_top dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ctx_irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  // monitor: pops the expected item for each read response
  always @(posedge clk) begin
    if (req && !we) begin
      #2;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rd(C0_CLM, 0, "R1 claim empty");
    rd(22'd12, 0, "R1 priority zero");
    rd(C0_EN, 0, "R1 enable zero");
    rd(C1_THR, 0, "R1 threshold zero");

    wr(22'd12, 32'hFFFF_FFFF);
    rd(22'd12, 32'h7, "R2 priority width");
    wr(22'd0, 32'h5);
    rd(22'd0, 0, "R2 source 0 absent");
    wr(C0_EN, 32'hFFFF_FFFF);
    rd(C0_EN, 32'hFFFF_FFFE, "R3 enable bit0 zero");
    rd(C1_EN, 0, "R3 ctx1 enable separate");
    wr(C0_EN, 0);
    wr(C0_THR, 32'hFF);
    rd(C0_THR, 32'h7, "R4 threshold width");
    wr(C0_THR, 0);

    // level source 3 (bit 2), priority 2
    wr(22'd12, 2);
    src[2] = 1'b1;
    settle();
    chk("R5 disabled source no irq", 32'(irq[0]), 0);
    wr(C0_EN, 32'h8);
    chk("R6 irq not yet", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R6 irq one cycle later", 32'(irq[0]), 1);
    wr(C0_THR, 2); settle();
    chk("R5 equal threshold blocks", 32'(irq[0]), 0);
    wr(C0_THR, 1); settle();
    chk("R5 lower threshold passes", 32'(irq[0]), 1);
    wr(22'd12, 7); wr(C0_THR, 7); settle();
    chk("R5 threshold 7 blocks", 32'(irq[0]), 0);
    wr(C0_THR, 0); wr(22'd12, 0); settle();
    chk("R5 priority 0 never", 32'(irq[0]), 0);
    wr(22'd12, 2);

    // arbitration: 5 and 6 at priority 4, 3 at priority 2
    wr(22'd20, 4); wr(22'd24, 4);
    wr(C0_EN, 32'h68);
    src[4] = 1'b1; src[5] = 1'b1;
    settle();
    rd(C0_CLM, 5, "R7 tie lowest id");
    rd(C0_CLM, 6, "R7 next equal");
    rd(C0_CLM, 3, "R7 lower priority last");
    rd(C0_CLM, 0, "R8 all in flight");
    settle();
    chk("R8 irq low while lines held", 32'(irq[0]), 0);
    wr(C0_CLM, 5); settle();
    rd(C0_CLM, 5, "R9 level rearm");
    wr(C1_CLM, 5); settle();
    rd(C0_CLM, 0, "R11 wrong context completion");
    wr(C0_CLM, 9); settle();
    rd(C0_CLM, 0, "R11 stray id completion");
    wr(C0_CLM, 5); settle();
    rd(C0_CLM, 5, "R9 rearm after proper completion");
    src = '0;
    wr(C0_CLM, 5); wr(C0_CLM, 6); wr(C0_CLM, 3); settle();
    rd(C0_CLM, 0, "R9 dropped lines stay idle");
    chk("R9 irq idle", 32'(irq[0]), 0);

    // edge source 20 (bit 19)
    wr(22'd80, 3); wr(C0_EN, 32'h0010_0000);
    src[19] = 1'b1; settle();
    chk("R10 edge raises irq", 32'(irq[0]), 1);
    rd(C0_CLM, 20, "R10 edge claim");
    @(negedge clk); src[19] = 1'b0;
    @(negedge clk); src[19] = 1'b1;
    settle();
    wr(C0_CLM, 20); settle();
    rd(C0_CLM, 0, "R10 in-flight edge dropped");
    src[19] = 1'b0; settle();
    src[19] = 1'b1; settle();
    rd(C0_CLM, 20, "R10 fresh edge captured");
    wr(C0_CLM, 20); src[19] = 1'b0; settle();

    // context independence, source 7 (bit 6)
    wr(C0_EN, 0); wr(22'd28, 1); wr(C1_EN, 32'h80);
    src[6] = 1'b1; settle();
    chk("R12 ctx1 irq", 32'(irq[1]), 1);
    chk("R12 ctx0 quiet", 32'(irq[0]), 0);
    rd(C0_CLM, 0, "R12 ctx0 claims nothing");
    rd(C1_CLM, 7, "R12 ctx1 claim");
    src[6] = 1'b0;
    wr(C1_CLM, 7); settle();
    chk("R12 ctx1 idle after completion", 32'(irq[1]), 0);

    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule